// File: doc/BRIEF.md
# Event Notification Routing Sequencer

This block takes one event trigger at a time and carries it through a fixed routing sequence. A trigger names an event descriptor by a block number and an index, and carries 31 bits of event data. The descriptor can append that data to a circular event queue in memory through a one-cycle write port. It then applies two-bit coalescing state and asks an external presenter, over a request/acknowledge handshake, whether the target virtual processor is dispatched. If the target is not dispatched, a pending-priority bitmap is recorded on the target entry. At the end, the descriptor can re-enter the sequence once through an escalation descriptor.

The descriptor table and the target table are held in internal register arrays. They are loaded through a configuration write port while the sequencer is idle, and either table can be observed through combinational peek ports. Each finished sequence raises a one-cycle done pulse that carries a result code. The code values are 0 for none, 1 for an invalid descriptor, 2 for an invalid target, 3 for backlog combined with format 1, and 4 for escalation depth exceeded.

Top module: `evt_route_seq`

## Requirements
- R1: After reset the trigger input is ready, no memory write, presenter request or done pulse is active, and every table entry reads back as invalid.
- R2: When the enqueue flag is set, exactly one memory write is issued. Its address is queue base + 4 * queue index, and its word is the generation bit in bit 31 above event data bits 30..0.
- R3: After each enqueue the index advances modulo 2^(qsize + QLOG_MIN). When it wraps to zero, the generation bit inverts and the generation-flipped bit takes the new generation value.
- R4: A trigger that reaches a descriptor whose valid bit is clear ends with result code 1 and nothing else happens.
- R5: A descriptor with the silent flag never asks the presenter and goes straight to the escalation step.
- R6: Format 0 with priority 0xFF is masked: the sequence ends with code 0 after the optional enqueue and asks no presenter.
- R7: With always-notify clear, the notification state is stepped (bit 1 pending, bit 0 queued): 00 becomes 10 and notifies, 10 and 11 become 11 without notifying, and 01 stays 01 without notifying. A sequence that does not notify stops there.
- R8: With always-notify set, the notification state is left untouched and the presenter is always asked.
- R9: The presenter request holds the target, priority and format steady until acknowledged. A "found" answer ends the sequence with code 0.
- R10: A "not found" answer with backlog set ORs bit (7 - priority) into the target's 8-bit pending bitmap. With format 1, it instead ends with code 3 and leaves the bitmap untouched.
- R11: A descriptor whose target entry is invalid ends with code 2 and asks no presenter.
- R12: The escalation step runs only with the escalate flag set. Unless the unconditional flag is set, it steps the separate escalation state by the R7 rule and stops when no notification results. Otherwise it re-enters with the descriptor's escalation block, index and data.
- R13: A sequence that has already escalated once and reaches an escalate request again ends with code 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Event trigger present |
| trig_ready | output | 1 | Sequencer idle and accepting a trigger |
| trig_blk | input | BLK_W | Descriptor block number |
| trig_idx | input | IDX_W | Descriptor index within the block |
| trig_data | input | 31 | Event data |
| cfg_we | input | 1 | Table write, honoured while idle; takes precedence over a trigger |
| cfg_sel_tgt | input | 1 | 1 writes the target table, 0 writes the descriptor table |
| cfg_desc_addr | input | BLK_W+IDX_W | Descriptor entry to write |
| cfg_desc | input | DESC_BITS | Descriptor contents (package struct layout) |
| cfg_tgt_addr | input | TGT_W | Target entry to write |
| cfg_tgt | input | TGT_BITS | Target contents: valid bit and pending bitmap |
| peek_desc_addr | input | BLK_W+IDX_W | Descriptor entry to observe |
| peek_desc | output | DESC_BITS | Observed descriptor |
| peek_tgt_addr | input | TGT_W | Target entry to observe |
| peek_tgt | output | TGT_BITS | Observed target |
| mem_we | output | 1 | Queue memory write strobe |
| mem_addr | output | QADDR_W | Queue write byte address |
| mem_wdata | output | 32 | Queue word |
| pres_req | output | 1 | Presenter lookup request |
| pres_fmt | output | 1 | Notification format |
| pres_tgt | output | TGT_W | Target entry number |
| pres_prio | output | PRIO_W | Notification priority |
| pres_ack | input | 1 | Presenter answer valid |
| pres_found | input | 1 | Target dispatched |
| seq_done | output | 1 | Sequence finished (one-cycle pulse) |
| seq_err | output | 3 | Result code of the finished sequence |

## Verification
A run of nine back-to-back enqueues on a four-entry queue checks the address stepping, the generation toggle at the first wrap and the flipped bit at the second wrap, which a design that never wraps or never flips would get wrong. Repeated triggers on one coalescing descriptor separate the four state transitions from an always-notify descriptor whose state must not move. Presenter answers of found and not found, with and without backlog and in both formats, separate the early end, the bitmap update and the configuration error. Silent, conditional, unconditional and self-referencing escalation descriptors show that re-entry happens once and that a second request is refused.

// File: rtl/evt_route_pkg.sv
package evt_route_pkg;

   localparam int BLK_W   = 1;
   localparam int IDX_W   = 2;
   localparam int TGT_W   = 3;
   localparam int QADDR_W = 16;
   localparam int QIDX_W  = 13;
   localparam int QSIZE_W = 2;
   localparam int PRIO_W  = 8;
   localparam int DATA_W  = 31;
   localparam int PEND_W  = 8;
   localparam int DESC_AW = BLK_W + IDX_W;

   // two-bit coalescing state: bit 1 pending, bit 0 queued
   localparam logic [1:0] ES_IDLE   = 2'b00;
   localparam logic [1:0] ES_OFF    = 2'b01;
   localparam logic [1:0] ES_PEND   = 2'b10;
   localparam logic [1:0] ES_QUEUED = 2'b11;

   typedef struct packed {
      logic                valid;
      logic                enq;
      logic                silent;
      logic                always_ntf;
      logic                backlog;
      logic                escalate;
      logic                uncond;
      logic                fmt;
      logic [QADDR_W-1:0]  qbase;
      logic [QSIZE_W-1:0]  qsize;
      logic [QIDX_W-1:0]   qidx;
      logic                gen;
      logic                gen_flip;
      logic [1:0]          es_ntf;
      logic [1:0]          es_esc;
      logic [PRIO_W-1:0]   prio;
      logic [TGT_W-1:0]    tgt;
      logic [BLK_W-1:0]    esc_blk;
      logic [IDX_W-1:0]    esc_idx;
      logic [DATA_W-1:0]   esc_data;
   } desc_t;

   typedef struct packed {
      logic              valid;
      logic [PEND_W-1:0] pend;
   } tgt_t;

   localparam int DESC_BITS = $bits(desc_t);
   localparam int TGT_BITS  = $bits(tgt_t);

   typedef enum logic [2:0] {
      RC_NONE  = 3'd0,
      RC_DESC  = 3'd1,
      RC_TGT   = 3'd2,
      RC_CFG   = 3'd3,
      RC_DEPTH = 3'd4
   } rcode_e;

   typedef enum logic [2:0] {
      S_IDLE, S_FETCH, S_ENQ, S_ROUTE, S_TGT, S_PRES, S_ESC
   } st_e;

endpackage

// File: rtl/evt_es_rule.sv
module evt_es_rule
   import evt_route_pkg::*;
(
   input  logic [1:0] cur,
   output logic [1:0] nxt,
   output logic       fire
);

   always_comb begin
      nxt  = cur;
      fire = 1'b0;
      case (cur)
         ES_IDLE: begin
            nxt  = ES_PEND;
            fire = 1'b1;
         end
         ES_PEND, ES_QUEUED: nxt = ES_QUEUED;
         default: nxt = cur;
      endcase
   end

endmodule

// File: rtl/evt_q_step.sv
module evt_q_step
   import evt_route_pkg::*;
#(
   parameter int QLOG_MIN = 10
)(
   input  logic [QADDR_W-1:0] qbase,
   input  logic [QSIZE_W-1:0] qsize,
   input  logic [QIDX_W-1:0]  qidx,
   input  logic               gen,
   input  logic [DATA_W-1:0]  data,
   output logic [QADDR_W-1:0] addr,
   output logic [31:0]        word,
   output logic [QIDX_W-1:0]  nidx,
   output logic               ngen,
   output logic               wrap
);

   localparam int NSZ = 1 << QSIZE_W;

   if (QLOG_MIN < 1) begin : g_bad_min
      $error("QLOG_MIN must be at least 1");
   end
   if (QLOG_MIN + NSZ - 1 > QIDX_W) begin : g_bad_idx
      $error("queue index field too narrow for largest queue");
   end

   logic [QIDX_W-1:0] mask_tab [NSZ];

   for (genvar s = 0; s < NSZ; s++) begin : g_sz
      assign mask_tab[s] = QIDX_W'((64'd1 << (s + QLOG_MIN)) - 64'd1);
   end

   logic [QIDX_W-1:0] mask;
   assign mask = mask_tab[qsize];

   assign addr = qbase + QADDR_W'({qidx, 2'b00});
   assign word = {gen, data};
   assign nidx = (qidx + QIDX_W'(1)) & mask;
   assign wrap = (nidx == '0);
   assign ngen = wrap ? ~gen : gen;

endmodule

// File: rtl/evt_prio_map.sv
module evt_prio_map
   import evt_route_pkg::*;
(
   input  logic [PRIO_W-1:0] prio,
   output logic [PEND_W-1:0] bits
);

   if (PRIO_W < $clog2(PEND_W)) begin : g_bad_w
      $error("priority field too narrow for pending bitmap");
   end

   for (genvar b = 0; b < PEND_W; b++) begin : g_bit
      assign bits[b] = (prio == PRIO_W'(PEND_W - 1 - b));
   end

endmodule

// File: rtl/evt_route_seq.sv
module evt_route_seq
   import evt_route_pkg::*;
#(
   parameter int QLOG_MIN = 10
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 trig_valid,
   output logic                 trig_ready,
   input  logic [BLK_W-1:0]     trig_blk,
   input  logic [IDX_W-1:0]     trig_idx,
   input  logic [DATA_W-1:0]    trig_data,
   input  logic                 cfg_we,
   input  logic                 cfg_sel_tgt,
   input  logic [DESC_AW-1:0]   cfg_desc_addr,
   input  logic [DESC_BITS-1:0] cfg_desc,
   input  logic [TGT_W-1:0]     cfg_tgt_addr,
   input  logic [TGT_BITS-1:0]  cfg_tgt,
   input  logic [DESC_AW-1:0]   peek_desc_addr,
   output logic [DESC_BITS-1:0] peek_desc,
   input  logic [TGT_W-1:0]     peek_tgt_addr,
   output logic [TGT_BITS-1:0]  peek_tgt,
   output logic                 mem_we,
   output logic [QADDR_W-1:0]   mem_addr,
   output logic [31:0]          mem_wdata,
   output logic                 pres_req,
   output logic                 pres_fmt,
   output logic [TGT_W-1:0]     pres_tgt,
   output logic [PRIO_W-1:0]    pres_prio,
   input  logic                 pres_ack,
   input  logic                 pres_found,
   output logic                 seq_done,
   output logic [2:0]           seq_err
);

   localparam int NDESC = 1 << DESC_AW;
   localparam int NTGT  = 1 << TGT_W;

   desc_t              desc_tab [NDESC];
   tgt_t               tgt_tab  [NTGT];
   st_e                st;
   logic [DESC_AW-1:0] cur;
   logic [DATA_W-1:0]  cur_data;
   logic               depth;
   logic               done_q;
   rcode_e             rc_q;

   desc_t d;
   tgt_t  t;
   assign d = desc_tab[cur];
   assign t = tgt_tab[d.tgt];

   // queue write arithmetic
   logic [QADDR_W-1:0] q_addr;
   logic [31:0]        q_word;
   logic [QIDX_W-1:0]  q_nidx;
   logic               q_ngen;
   logic               q_wrap;

   evt_q_step #(.QLOG_MIN(QLOG_MIN)) u_qstep (
      .qbase (d.qbase),
      .qsize (d.qsize),
      .qidx  (d.qidx),
      .gen   (d.gen),
      .data  (cur_data),
      .addr  (q_addr),
      .word  (q_word),
      .nidx  (q_nidx),
      .ngen  (q_ngen),
      .wrap  (q_wrap)
   );

   // coalescing rules for notification and escalation
   logic [1:0] n_nxt, e_nxt;
   logic       n_fire, e_fire;

   evt_es_rule u_rule_ntf (.cur(d.es_ntf), .nxt(n_nxt), .fire(n_fire));
   evt_es_rule u_rule_esc (.cur(d.es_esc), .nxt(e_nxt), .fire(e_fire));

   logic [PEND_W-1:0] prio_bits;
   evt_prio_map u_pmap (.prio(d.prio), .bits(prio_bits));

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         cur      <= '0;
         cur_data <= '0;
         depth    <= 1'b0;
         done_q   <= 1'b0;
         rc_q     <= RC_NONE;
         for (int i = 0; i < NDESC; i++) desc_tab[i] <= '0;
         for (int i = 0; i < NTGT; i++)  tgt_tab[i]  <= '0;
      end else begin
         done_q <= 1'b0;
         case (st)
            S_IDLE: begin
               if (cfg_we) begin
                  if (cfg_sel_tgt) tgt_tab[cfg_tgt_addr]   <= tgt_t'(cfg_tgt);
                  else             desc_tab[cfg_desc_addr] <= desc_t'(cfg_desc);
               end else if (trig_valid) begin
                  cur      <= {trig_blk, trig_idx};
                  cur_data <= trig_data;
                  depth    <= 1'b0;
                  st       <= S_FETCH;
               end
            end
            S_FETCH: begin
               if (!d.valid) begin
                  st <= S_IDLE; done_q <= 1'b1; rc_q <= RC_DESC;
               end else begin
                  st <= d.enq ? S_ENQ : S_ROUTE;
               end
            end
            S_ENQ: begin
               desc_tab[cur].qidx <= q_nidx;
               desc_tab[cur].gen  <= q_ngen;
               if (q_wrap) desc_tab[cur].gen_flip <= q_ngen;
               st <= S_ROUTE;
            end
            S_ROUTE: begin
               if (d.silent) begin
                  st <= S_ESC;
               end else if (!d.fmt && (d.prio == '1)) begin
                  st <= S_IDLE; done_q <= 1'b1; rc_q <= RC_NONE;
               end else if (!d.always_ntf) begin
                  if (n_nxt != d.es_ntf) desc_tab[cur].es_ntf <= n_nxt;
                  if (n_fire) begin
                     st <= S_TGT;
                  end else begin
                     st <= S_IDLE; done_q <= 1'b1; rc_q <= RC_NONE;
                  end
               end else begin
                  st <= S_TGT;
               end
            end
            S_TGT: begin
               if (!t.valid) begin
                  st <= S_IDLE; done_q <= 1'b1; rc_q <= RC_TGT;
               end else begin
                  st <= S_PRES;
               end
            end
            S_PRES: begin
               if (pres_ack) begin
                  if (pres_found) begin
                     st <= S_IDLE; done_q <= 1'b1; rc_q <= RC_NONE;
                  end else if (d.backlog && d.fmt) begin
                     st <= S_IDLE; done_q <= 1'b1; rc_q <= RC_CFG;
                  end else begin
                     if (d.backlog) tgt_tab[d.tgt].pend <= t.pend | prio_bits;
                     st <= S_ESC;
                  end
               end
            end
            S_ESC: begin
               if (!d.escalate) begin
                  st <= S_IDLE; done_q <= 1'b1; rc_q <= RC_NONE;
               end else if (depth) begin
                  st <= S_IDLE; done_q <= 1'b1; rc_q <= RC_DEPTH;
               end else begin
                  if (!d.uncond && (e_nxt != d.es_esc)) desc_tab[cur].es_esc <= e_nxt;
                  if (d.uncond || e_fire) begin
                     cur      <= {d.esc_blk, d.esc_idx};
                     cur_data <= d.esc_data;
                     depth    <= 1'b1;
                     st       <= S_FETCH;
                  end else begin
                     st <= S_IDLE; done_q <= 1'b1; rc_q <= RC_NONE;
                  end
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign trig_ready = (st == S_IDLE) && !cfg_we;
   assign mem_we     = (st == S_ENQ);
   assign mem_addr   = q_addr;
   assign mem_wdata  = q_word;
   assign pres_req   = (st == S_PRES);
   assign pres_fmt   = d.fmt;
   assign pres_tgt   = d.tgt;
   assign pres_prio  = d.prio;
   assign seq_done   = done_q;
   assign seq_err    = rc_q;
   assign peek_desc  = desc_tab[peek_desc_addr];
   assign peek_tgt   = tgt_tab[peek_tgt_addr];

   // checks beside the logic
   AST_ENQ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we); // R2

   AST_WRAP_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && q_wrap) |=> (d.gen != $past(d.gen)) && (d.gen_flip == d.gen)); // R3

   AST_NOWRAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !q_wrap) |=> (d.gen == $past(d.gen))); // R3

   AST_PRES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pres_req && !pres_ack) |=> pres_req && $stable(pres_prio) && $stable(pres_tgt)); // R9

   AST_DEPTH_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_ESC && depth && d.escalate) |=> seq_done && (seq_err == 3'(RC_DEPTH))); // R13

   AST_SILENT_NOPRES: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_ROUTE && d.silent) |=> !pres_req); // R5

endmodule

// File: tb/evt_route_seq_tb.sv
module evt_route_seq_tb;
   import evt_route_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic                 trig_valid = 1'b0;
   logic                 trig_ready;
   logic [BLK_W-1:0]     trig_blk = '0;
   logic [IDX_W-1:0]     trig_idx = '0;
   logic [DATA_W-1:0]    trig_data = '0;
   logic                 cfg_we = 1'b0;
   logic                 cfg_sel_tgt = 1'b0;
   logic [DESC_AW-1:0]   cfg_desc_addr = '0;
   logic [DESC_BITS-1:0] cfg_desc = '0;
   logic [TGT_W-1:0]     cfg_tgt_addr = '0;
   logic [TGT_BITS-1:0]  cfg_tgt = '0;
   logic [DESC_AW-1:0]   peek_desc_addr = '0;
   logic [DESC_BITS-1:0] peek_desc;
   logic [TGT_W-1:0]     peek_tgt_addr = '0;
   logic [TGT_BITS-1:0]  peek_tgt;
   logic                 mem_we;
   logic [QADDR_W-1:0]   mem_addr;
   logic [31:0]          mem_wdata;
   logic                 pres_req;
   logic                 pres_fmt;
   logic [TGT_W-1:0]     pres_tgt;
   logic [PRIO_W-1:0]    pres_prio;
   logic                 pres_ack = 1'b0;
   logic                 pres_found = 1'b0;
   logic                 seq_done;
   logic [2:0]           seq_err;

   evt_route_seq #(.QLOG_MIN(2)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .trig_valid(trig_valid), .trig_ready(trig_ready),
      .trig_blk(trig_blk), .trig_idx(trig_idx), .trig_data(trig_data),
      .cfg_we(cfg_we), .cfg_sel_tgt(cfg_sel_tgt),
      .cfg_desc_addr(cfg_desc_addr), .cfg_desc(cfg_desc),
      .cfg_tgt_addr(cfg_tgt_addr), .cfg_tgt(cfg_tgt),
      .peek_desc_addr(peek_desc_addr), .peek_desc(peek_desc),
      .peek_tgt_addr(peek_tgt_addr), .peek_tgt(peek_tgt),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .pres_req(pres_req), .pres_fmt(pres_fmt), .pres_tgt(pres_tgt),
      .pres_prio(pres_prio), .pres_ack(pres_ack), .pres_found(pres_found),
      .seq_done(seq_done), .seq_err(seq_err)
   );

   int total = 0;
   int bad = 0;
   int pres_cnt = 0;
   logic [PRIO_W-1:0] last_prio = '0;
   logic [TGT_W-1:0]  last_tgt = '0;
   logic found_cfg = 1'b1;
   logic pres_wait = 1'b0;
   bit   finished = 1'b0;

   logic [47:0] mem_q[$];
   logic [2:0]  rc_q[$];
   string       tag_q[$];

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // presenter model: acknowledges on the second cycle of a request
   always @(negedge clk) begin
      if (pres_req && !pres_ack) begin
         if (pres_wait) begin
            pres_ack   = 1'b1;
            pres_found = found_cfg;
            pres_cnt++;
            last_prio  = pres_prio;
            last_tgt   = pres_tgt;
            pres_wait  = 1'b0;
         end else begin
            pres_wait = 1'b1;
         end
      end else begin
         pres_ack = 1'b0;
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_we) begin
            if (mem_q.size() == 0) chk(1'b0, "R2 unexpected queue write", {mem_addr, mem_wdata}, 0);
            else begin
               logic [47:0] e;
               e = mem_q.pop_front();
               chk({mem_addr, mem_wdata} == e, "R2 R3 queue write", {mem_addr, mem_wdata}, e);
            end
         end
         if (seq_done) begin
            if (rc_q.size() == 0) chk(1'b0, "unexpected sequence end", seq_err, 0);
            else begin
               logic [2:0] e;
               string tg;
               e  = rc_q.pop_front();
               tg = tag_q.pop_front();
               chk(seq_err == e, tg, seq_err, e);
            end
         end
      end
   end

   task automatic put_desc(input int a, input desc_t x);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel_tgt = 1'b0;
      cfg_desc_addr = DESC_AW'(a); cfg_desc = x;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic put_tgt(input int a, input logic v, input logic [PEND_W-1:0] p);
      tgt_t x;
      x.valid = v; x.pend = p;
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel_tgt = 1'b1;
      cfg_tgt_addr = TGT_W'(a); cfg_tgt = x;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic expect_end(input rcode_e rc, input string tg);
      rc_q.push_back(rc);
      tag_q.push_back(tg);
   endtask

   task automatic expect_wr(input logic [15:0] a, input logic g, input logic [30:0] dat);
      mem_q.push_back({a, g, dat});
   endtask

   task automatic fire(input int a, input logic [30:0] dat);
      @(negedge clk);
      while (!trig_ready) @(negedge clk);
      trig_valid = 1'b1;
      {trig_blk, trig_idx} = DESC_AW'(a);
      trig_data = dat;
      @(negedge clk);
      trig_valid = 1'b0;
      while (!seq_done) @(negedge clk);
   endtask

   function automatic desc_t base_desc();
      desc_t x;
      x = '0;
      x.valid = 1'b1;
      return x;
   endfunction

   task automatic peek_d(input int a, output desc_t x);
      peek_desc_addr = DESC_AW'(a);
      #1;
      x = desc_t'(peek_desc);
   endtask

   task automatic peek_t(input int a, output tgt_t x);
      peek_tgt_addr = TGT_W'(a);
      #1;
      x = tgt_t'(peek_tgt);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "watchdog expired", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      desc_t dx;
      tgt_t  tx;
      int    pc;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      peek_d(0, dx);
      chk(trig_ready == 1'b1, "R1 ready after reset", trig_ready, 1);
      chk(!mem_we && !pres_req && !seq_done, "R1 outputs idle", {mem_we, pres_req, seq_done}, 0);
      chk(dx.valid == 1'b0, "R1 table cleared", dx.valid, 0);

      // targets
      put_tgt(1, 1'b1, 8'h00);
      put_tgt(2, 1'b1, 8'h00);
      put_tgt(3, 1'b1, 8'h01);

      // R2 R3 R8 R9: enqueue on four-entry queue, always-notify, found
      dx = base_desc();
      dx.enq = 1'b1; dx.always_ntf = 1'b1; dx.qbase = 16'h0100; dx.gen = 1'b1;
      dx.prio = 8'd3; dx.tgt = 3'd1;
      put_desc(0, dx);
      found_cfg = 1'b1;
      pc = pres_cnt;
      for (int k = 0; k < 9; k++) begin
         logic g;
         g = (k < 4) ? 1'b1 : ((k < 8) ? 1'b0 : 1'b1);
         expect_wr(16'h0100 + 16'(4 * (k % 4)), g, 31'(32'h100 + k));
         expect_end(RC_NONE, "R9 found ends sequence");
         fire(0, 31'(32'h100 + k));
         if (k == 3) begin
            peek_d(0, dx);
            chk(dx.gen == 1'b0 && dx.gen_flip == 1'b0 && dx.qidx == 0, "R3 first wrap",
                {dx.gen, dx.gen_flip, dx.qidx}, 0);
         end
      end
      peek_d(0, dx);
      chk(dx.gen == 1'b1 && dx.gen_flip == 1'b1 && dx.qidx == 1, "R3 second wrap",
          {dx.gen, dx.gen_flip, dx.qidx}, {1'b1, 1'b1, 13'd1});
      chk(dx.es_ntf == ES_IDLE, "R8 state untouched", dx.es_ntf, ES_IDLE);
      chk(pres_cnt == pc + 9, "R8 presenter asked each time", pres_cnt - pc, 9);
      chk(last_prio == 8'd3 && last_tgt == 3'd1, "R9 request fields", {last_prio, last_tgt}, {8'd3, 3'd1});

      // R4 invalid descriptor
      expect_end(RC_DESC, "R4 invalid descriptor");
      fire(5, 31'h55);

      // R6 masked descriptor still enqueues
      dx = base_desc();
      dx.enq = 1'b1; dx.qbase = 16'h0200; dx.prio = 8'hFF;
      put_desc(1, dx);
      pc = pres_cnt;
      expect_wr(16'h0200, 1'b0, 31'h1234567);
      expect_end(RC_NONE, "R6 masked end");
      fire(1, 31'h1234567);
      chk(pres_cnt == pc, "R6 no presenter", pres_cnt - pc, 0);

      // R7 coalescing
      dx = base_desc();
      dx.prio = 8'd2; dx.tgt = 3'd2;
      put_desc(2, dx);
      pc = pres_cnt;
      expect_end(RC_NONE, "R7 first notify");
      fire(2, 31'h1);
      peek_d(2, dx);
      chk(dx.es_ntf == ES_PEND && pres_cnt == pc + 1, "R7 00 to 10 notifies", {dx.es_ntf, pres_cnt - pc}, {2'b10, 32'd1});
      expect_end(RC_NONE, "R7 coalesced");
      fire(2, 31'h2);
      peek_d(2, dx);
      chk(dx.es_ntf == ES_QUEUED && pres_cnt == pc + 1, "R7 10 to 11 silent", {dx.es_ntf, pres_cnt - pc}, {2'b11, 32'd1});
      expect_end(RC_NONE, "R7 coalesced again");
      fire(2, 31'h3);
      peek_d(2, dx);
      chk(dx.es_ntf == ES_QUEUED && pres_cnt == pc + 1, "R7 11 stays", {dx.es_ntf, pres_cnt - pc}, {2'b11, 32'd1});
      dx.es_ntf = ES_OFF;
      put_desc(2, dx);
      expect_end(RC_NONE, "R7 off state");
      fire(2, 31'h4);
      peek_d(2, dx);
      chk(dx.es_ntf == ES_OFF && pres_cnt == pc + 1, "R7 01 stays off", {dx.es_ntf, pres_cnt - pc}, {2'b01, 32'd1});

      // R10 backlog records pending bit
      dx = base_desc();
      dx.always_ntf = 1'b1; dx.backlog = 1'b1; dx.prio = 8'd5; dx.tgt = 3'd3;
      put_desc(3, dx);
      found_cfg = 1'b0;
      expect_end(RC_NONE, "R10 backlog end");
      fire(3, 31'h9);
      peek_t(3, tx);
      chk(tx.pend == 8'h05, "R10 pending bit", tx.pend, 8'h05);

      // R10 backlog with format 1
      dx = base_desc();
      dx.always_ntf = 1'b1; dx.backlog = 1'b1; dx.fmt = 1'b1; dx.prio = 8'd0; dx.tgt = 3'd3;
      put_desc(4, dx);
      expect_end(RC_CFG, "R10 format 1 backlog error");
      fire(4, 31'h9);
      peek_t(3, tx);
      chk(tx.pend == 8'h05, "R10 bitmap untouched on error", tx.pend, 8'h05);

      // R11 invalid target
      dx = base_desc();
      dx.always_ntf = 1'b1; dx.prio = 8'd1; dx.tgt = 3'd7;
      put_desc(6, dx);
      pc = pres_cnt;
      expect_end(RC_TGT, "R11 invalid target");
      fire(6, 31'h7);
      chk(pres_cnt == pc, "R11 no presenter", pres_cnt - pc, 0);

      // R5 R12 silent conditional escalation into descriptor 1
      dx = base_desc();
      dx.silent = 1'b1; dx.escalate = 1'b1; dx.prio = 8'd4; dx.tgt = 3'd1;
      dx.esc_blk = 1'b0; dx.esc_idx = 2'd1; dx.esc_data = 31'h0ABCDE;
      put_desc(7, dx);
      pc = pres_cnt;
      expect_wr(16'h0204, 1'b0, 31'h0ABCDE);
      expect_end(RC_NONE, "R12 escalated end");
      fire(7, 31'h3);
      peek_d(7, dx);
      chk(dx.es_esc == ES_PEND, "R12 escalation state stepped", dx.es_esc, ES_PEND);
      chk(pres_cnt == pc, "R5 silent skips presenter", pres_cnt - pc, 0);
      expect_end(RC_NONE, "R12 escalation coalesced");
      fire(7, 31'h3);
      peek_d(7, dx);
      chk(dx.es_esc == ES_QUEUED, "R12 escalation coalesced state", dx.es_esc, ES_QUEUED);
      dx.uncond = 1'b1;
      put_desc(7, dx);
      expect_wr(16'h0208, 1'b0, 31'h0ABCDE);
      expect_end(RC_NONE, "R12 unconditional escalation");
      fire(7, 31'h3);
      peek_d(7, dx);
      chk(dx.es_esc == ES_QUEUED, "R12 unconditional leaves state", dx.es_esc, ES_QUEUED);

      // R13 self-escalating descriptor
      dx = base_desc();
      dx.silent = 1'b1; dx.escalate = 1'b1; dx.uncond = 1'b1;
      dx.esc_blk = 1'b1; dx.esc_idx = 2'd1;
      put_desc(5, dx);
      expect_end(RC_DEPTH, "R13 depth refused");
      fire(5, 31'h1);

      repeat (5) @(negedge clk);
      chk(mem_q.size() == 0, "R2 all queue writes seen", mem_q.size(), 0);
      chk(rc_q.size() == 0, "R4 all sequence ends seen", rc_q.size(), 0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule